// File: doc/BRIEF.md
# ICV Comparison and Result Reporter

This block sits behind a cipher execution unit. When a job finishes, the unit presents the integrity check value it computed, together with the value expected for that job. The block compares the two values over a programmable number of bytes. It then reports pass or fail to the host through exactly one of two paths. The first path is a request to write the status fields back to host memory. The second path is a done or error interrupt pulse.

The reporting path is chosen by three configuration inputs: two writeback-enable bits and a mask bit for the ICV-error interrupt. If writeback is enabled, the error interrupt must be masked. If interrupt reporting is wanted, both writeback bits must be clear and the error interrupt must be unmasked. Any other use of the writeback bits is rejected as a configuration error. If a job fails its check in interrupt mode, the block raises only the error interrupt. It issues no done pulse and no writeback.

All results appear one clock after the job-complete strobe and last one cycle.

Top module: `icv_check_reporter`

## Requirements
- R1: Byte i of each ICV occupies bits [8i+7:8i]. Byte i takes part in the comparison only when i < `icv_len`. Bytes at or above that length are ignored. A length above `MAX_BYTES` is treated as `MAX_BYTES`. A length of 0 always counts as a match.
- R2: When either writeback-enable bit is 1 and `icv_irq_mask` is 1, a job strobe produces `wb_req` on the following cycle. In that case `wb_icv_fail` is 1 if the ICVs differ and 0 if they match. No interrupt pulse is raised.
- R3: When both writeback-enable bits are 0, `icv_irq_mask` is 0 and the ICVs match, a job strobe produces `done_irq` on the following cycle.
- R4: When both writeback-enable bits are 0, `icv_irq_mask` is 0 and the ICVs differ, a job strobe produces `err_irq` on the following cycle. It produces neither `done_irq` nor `wb_req`.
- R5: When either writeback-enable bit is 1 and `icv_irq_mask` is 0, a job strobe produces `cfg_err_irq` on the following cycle and no other output. This holds whether or not the ICVs match.
- R6: When both writeback-enable bits are 0 and `icv_irq_mask` is 1, a matching job produces `done_irq`. A mismatching job produces no output.
- R7: Every output is high for exactly one cycle per job, and only in the cycle after `job_done` was sampled high. Strobes on consecutive cycles give pulses on consecutive cycles.
- R8: After reset, all outputs are 0.
- R9: In any cycle, at most one of `done_irq`, `err_irq`, `cfg_err_irq` and `wb_req` is high. `wb_icv_fail` is high only together with `wb_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| job_done | input | 1 | One-cycle strobe: the job is complete and the ICVs are valid |
| calc_icv | input | 8*MAX_BYTES | ICV computed by the execution unit |
| exp_icv | input | 8*MAX_BYTES | ICV supplied with the job |
| icv_len | input | $clog2(MAX_BYTES+1) | Number of bytes to compare |
| wb_en_a | input | 1 | First writeback-enable configuration bit |
| wb_en_b | input | 1 | Second writeback-enable configuration bit |
| icv_irq_mask | input | 1 | 1 masks the ICV-error interrupt |
| done_irq | output | 1 | Done interrupt pulse |
| err_irq | output | 1 | ICV-mismatch error interrupt pulse |
| cfg_err_irq | output | 1 | Conflicting-configuration error pulse |
| wb_req | output | 1 | Status-writeback request pulse |
| wb_icv_fail | output | 1 | Pass/fail field carried with `wb_req` (1 = fail) |

## Verification
The bench builds the block with `MAX_BYTES` at its default of 16, which makes `icv_len` five bits wide.

Because the length input is five bits wide, the bench can drive the full sixteen-byte comparison. It can also drive lengths from 17 to 31, which exercise the clamp. The bench places a differing byte just inside and just outside the programmed length, and at the topmost byte. This shows that truncation happens at the correct byte boundary.

// File: rtl/icv_check_reporter.sv
module icv_check_reporter #(
  parameter int MAX_BYTES = 16,
  localparam int LEN_W = $clog2(MAX_BYTES + 1),
  localparam int ICV_W = 8 * MAX_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             job_done,
  input  logic [ICV_W-1:0] calc_icv,
  input  logic [ICV_W-1:0] exp_icv,
  input  logic [LEN_W-1:0] icv_len,
  input  logic             wb_en_a,
  input  logic             wb_en_b,
  input  logic             icv_irq_mask,
  output logic             done_irq,
  output logic             err_irq,
  output logic             cfg_err_irq,
  output logic             wb_req,
  output logic             wb_icv_fail
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BYTES);

  logic [LEN_W-1:0]     eff_len;
  logic [MAX_BYTES-1:0] byte_diff;
  logic                 mismatch;
  logic                 wb_sel;
  logic                 irq_sel;
  logic                 conflict;

  assign eff_len = (icv_len > LEN_MAX) ? LEN_MAX : icv_len;

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
    localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
    assign byte_diff[i] = (IDX < eff_len) &&
                          (calc_icv[8*i +: 8] != exp_icv[8*i +: 8]);
  end

  assign mismatch = |byte_diff;
  assign wb_sel   = wb_en_a | wb_en_b;
  assign irq_sel  = ~wb_sel & ~icv_irq_mask;
  assign conflict = wb_sel & ~icv_irq_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_irq    <= 1'b0;
      err_irq     <= 1'b0;
      cfg_err_irq <= 1'b0;
      wb_req      <= 1'b0;
      wb_icv_fail <= 1'b0;
    end else begin
      done_irq    <= job_done & ~wb_sel & ~mismatch;
      err_irq     <= job_done & irq_sel & mismatch;
      cfg_err_irq <= job_done & conflict;
      wb_req      <= job_done & wb_sel & icv_irq_mask;
      wb_icv_fail <= job_done & wb_sel & icv_irq_mask & mismatch;
    end
  end

  // R7
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq || err_irq || cfg_err_irq || wb_req) |-> $past(job_done));

  // R9
  one_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done_irq, err_irq, cfg_err_irq, wb_req}) <= 1);

  // R9
  fail_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_icv_fail |-> wb_req);

  // R4
  err_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> $past(!wb_en_a && !wb_en_b && !icv_irq_mask));

  // R5
  cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(job_done && (wb_en_a || wb_en_b) && !icv_irq_mask) |-> cfg_err_irq);

  // R2
  wb_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> $past((wb_en_a || wb_en_b) && icv_irq_mask));

endmodule

// File: tb/tb_icv_check_reporter.sv
module tb_icv_check_reporter;
  localparam int MB = 16;
  localparam int LW = $clog2(MB + 1);
  localparam int W  = 8 * MB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic job_done = 1'b0;
  logic [W-1:0] calc_icv = '0;
  logic [W-1:0] exp_icv = '0;
  logic [LW-1:0] icv_len = '0;
  logic wb_en_a = 1'b0, wb_en_b = 1'b0, icv_irq_mask = 1'b0;
  logic done_irq, err_irq, cfg_err_irq, wb_req, wb_icv_fail;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  icv_check_reporter #(.MAX_BYTES(MB)) dut (
    .clk(clk), .rst_n(rst_n), .job_done(job_done),
    .calc_icv(calc_icv), .exp_icv(exp_icv), .icv_len(icv_len),
    .wb_en_a(wb_en_a), .wb_en_b(wb_en_b), .icv_irq_mask(icv_irq_mask),
    .done_irq(done_irq), .err_irq(err_irq), .cfg_err_irq(cfg_err_irq),
    .wb_req(wb_req), .wb_icv_fail(wb_icv_fail));

  function automatic logic [4:0] outs();
    return {done_irq, err_irq, cfg_err_irq, wb_req, wb_icv_fail};
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs {done,err,cfg,wb,fail} = %b, expected %b", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pattern(int seed);
    logic [W-1:0] v;
    for (int i = 0; i < MB; i++) v[8*i +: 8] = 8'(seed * 37 + i * 11 + 5);
    return v;
  endfunction

  // drive one job at a negedge, sample the pulse one negedge later, then its end
  task automatic run_job(string req, logic [W-1:0] c, logic [W-1:0] e,
                         logic [LW-1:0] len, logic a, logic b, logic m,
                         logic [4:0] exp);
    calc_icv = c; exp_icv = e; icv_len = len;
    wb_en_a = a; wb_en_b = b; icv_irq_mask = m;
    job_done = 1'b1;
    @(negedge clk);
    job_done = 1'b0;
    check(req, outs(), exp);
    @(negedge clk);
    check({req, " (R7 single pulse)"}, outs(), 5'b0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8 reset", outs(), 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", outs(), 5'b0);
  endtask

  task automatic t_irq_mode();
    logic [W-1:0] p = pattern(1);
    run_job("R3 irq match", p, p, LW'(16), 0, 0, 0, 5'b10000);
    run_job("R4 irq mismatch", p, p ^ 128'h1, LW'(16), 0, 0, 0, 5'b01000);
  endtask

  task automatic t_wb_mode();
    logic [W-1:0] p = pattern(2);
    run_job("R2 wb_a match", p, p, LW'(16), 1, 0, 1, 5'b00010);
    run_job("R2 wb_b mismatch", p, p ^ {8'h80, 120'h0}, LW'(16), 0, 1, 1, 5'b00011);
    run_job("R2 both wb mismatch", p, ~p, LW'(4), 1, 1, 1, 5'b00011);
  endtask

  task automatic t_conflict();
    logic [W-1:0] p = pattern(3);
    run_job("R5 conflict match", p, p, LW'(16), 1, 0, 0, 5'b00100);
    run_job("R5 conflict mismatch", p, ~p, LW'(16), 0, 1, 0, 5'b00100);
  endtask

  task automatic t_masked_no_wb();
    logic [W-1:0] p = pattern(4);
    run_job("R6 masked match", p, p, LW'(16), 0, 0, 1, 5'b10000);
    run_job("R6 masked mismatch", p, ~p, LW'(16), 0, 0, 1, 5'b00000);
  endtask

  task automatic t_length();
    logic [W-1:0] p = pattern(5);
    logic [W-1:0] d5 = p ^ ({{(W-8){1'b0}}, 8'hFF} << 40);
    run_job("R1 diff byte 5 len 5 ignored", p, d5, LW'(5), 0, 0, 0, 5'b10000);
    run_job("R1 diff byte 5 len 6 seen", p, d5, LW'(6), 0, 0, 0, 5'b01000);
    run_job("R1 len 0 matches", p, ~p, LW'(0), 0, 0, 0, 5'b10000);
    run_job("R1 len 31 clamps, top byte seen", p, p ^ {8'h01, 120'h0}, LW'(31), 0, 0, 0, 5'b01000);
    run_job("R1 len 17 clamps, match", p, p, LW'(17), 1, 0, 1, 5'b00010);
  endtask

  task automatic t_back_to_back();
    logic [W-1:0] p = pattern(6);
    calc_icv = p; exp_icv = p; icv_len = LW'(8);
    wb_en_a = 0; wb_en_b = 0; icv_irq_mask = 0;
    job_done = 1'b1;
    @(negedge clk);
    check("R7 first of two", outs(), 5'b10000);
    exp_icv = ~p;
    @(negedge clk);
    job_done = 1'b0;
    check("R7 second of two", outs(), 5'b01000);
    @(negedge clk);
    check("R7 idle after pair", outs(), 5'b00000);
    calc_icv = ~p;
    @(negedge clk);
    check("R7 no strobe, no output", outs(), 5'b00000);
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_irq_mode();
    t_wb_mode();
    t_conflict();
    t_masked_no_wb();
    t_length();
    t_back_to_back();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule